// File: doc/BRIEF.md
# Wormhole Input Port Controller

This block runs one input port of a wormhole-switched router that has a single flit queue per port. Flits come in marked as head, body or tail and are written into a small queue. When a head flit reaches the front of the queue while the port is free, the port takes the output index from an external route computer, which looks at the front flit's payload. The port then asks the switch allocator for that output. Once the allocator grants it, the port keeps the output for the whole packet and sends flits one at a time. Each flit it sends uses up one downstream credit.

Body and tail flits never get a route of their own. They leave on the output the head flit chose. Sending the tail flit frees the output and returns the port to idle. A stray body or tail flit that reaches the front while the port is idle is thrown away and reported on a one-cycle error pulse. Because there is only one queue, a packet that is stalled at the front holds back every flit behind it, including the head of a later packet that wants a free output.

Top module: `wh_inport_ctrl`

## Requirements
- R1: A flit is written when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low exactly while the queue holds DEPTH flits. Flits leave in the order they arrived.
- R2: The flit type field uses these codes: 01 for head, 10 for body and 11 for tail. The reserved code 00 is handled like a body flit.
- R3: When a head flit is at the front of the queue and the port is idle, the port stores `rc_port` at the next edge. From the following cycle it drives `sa_req` high, with `sa_port` equal to the stored route.
- R4: A cycle in which `sa_req` and `sa_grant` are both high moves the port to active. In the active state `sa_hold` is high, `sa_req` is low, and every flit of the packet goes out with `out_port` equal to the head's stored route. `rc_port` has no effect on body or tail flits.
- R5: A flit is sent only while the credit count is non-zero, and at most one flit is sent per cycle. The count starts at CRED_INIT. Each flit sent lowers it by one and each `cred_ret` pulse raises it by one.
- R6: The output link is registered. `out_valid`, `out_kind`, `out_data` and `out_port` show a flit in the cycle after the edge at which it left the queue.
- R7: Sending a tail flit returns the port to idle. `sa_hold` is low from the same cycle in which the tail appears on the output. Until the tail is sent, `sa_hold` stays high.
- R8: A flit that is not a head and that reaches the front of the queue while the port is idle is removed without being forwarded, and `err_proto` is high for exactly one cycle.
- R9: While the port waits for a grant or for credits, no flit behind the stalled one leaves the queue. This includes the head of a later packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An incoming flit is present |
| in_kind | input | 2 | Type code of the incoming flit |
| in_data | input | DW | Payload of the incoming flit |
| in_ready | output | 1 | The queue has room for a flit |
| rc_hdr | output | DW | Payload at the queue front, given to the route computer |
| rc_port | input | PW | Output index from the route computer |
| sa_req | output | 1 | Request to the switch allocator |
| sa_hold | output | 1 | The port holds its output for the current packet |
| sa_port | output | PW | Output that is requested or held |
| sa_grant | input | 1 | The allocator grants the requested output |
| out_valid | output | 1 | A flit is on the output link |
| out_kind | output | 2 | Type code of the outgoing flit |
| out_data | output | DW | Payload of the outgoing flit |
| out_port | output | PW | Output the flit is steered to |
| cred_ret | input | 1 | One downstream buffer slot has been freed |
| err_proto | output | 1 | A stray non-head flit was dropped |

## Verification
The bench sends whole packets whose body payloads carry route bits that differ from the head's route. This shows whether body and tail flits really reuse the stored route or pick up a new one from `rc_port`. Stray body flits and reserved-code flits are sent while the port is idle, to tell a drop from a forward. The allocator grant is then withheld while a second packet's head is queued, which tells a correct head-of-line stall apart from a port that lets later flits overtake. Finally, credits are withheld in the middle of a packet and handed back one at a time. This exposes an off-by-one in the credit count, the one-cycle output latency, and the exact cycle at which the output hold is released.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    FT_RSVD = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'b00,
    PS_WAIT   = 2'b01,
    PS_ACTIVE = 2'b10
  } port_state_e;
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, wptr_d;
  logic [AW:0]  rptr_q, rptr_d;

  always_comb begin
    wptr_d = wptr_q + {{AW{1'b0}}, wr_en};
    rptr_d = rptr_q + {{AW{1'b0}}, rd_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wptr_q[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rptr_q[AW-1:0]];
  assign count   = wptr_q - rptr_q;
endmodule

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
  parameter int CRED_INIT = 3,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] RST_VAL = CW'(CRED_INIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case ({give, take})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wh_port_fsm.sv
module wh_port_fsm
  import wh_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          front_vld,
  input  flit_kind_e    front_kind,
  input  logic [PW-1:0] rc_port,
  input  logic          sa_grant,
  input  logic          cred_avail,
  output logic [PW-1:0] route,
  output logic          pop,
  output logic          send,
  output logic          err_drop,
  output logic          sa_req,
  output logic          sa_hold
);
  port_state_e   st_q, st_d;
  logic [PW-1:0] route_q;
  logic          route_en;

  always_comb begin
    st_d     = st_q;
    route_en = 1'b0;
    pop      = 1'b0;
    send     = 1'b0;
    err_drop = 1'b0;
    sa_req   = 1'b0;
    sa_hold  = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        if (front_vld) begin
          if (front_kind == FT_HEAD) begin
            route_en = 1'b1;
            st_d     = PS_WAIT;
          end else begin
            pop      = 1'b1;
            err_drop = 1'b1;
          end
        end
      end
      PS_WAIT: begin
        sa_req = 1'b1;
        if (sa_grant) st_d = PS_ACTIVE;
      end
      PS_ACTIVE: begin
        sa_hold = 1'b1;
        if (front_vld && cred_avail) begin
          send = 1'b1;
          pop  = 1'b1;
          if (front_kind == FT_TAIL) st_d = PS_IDLE;
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        route_q <= '0;
    else if (route_en) route_q <= rc_port;
  end

  assign route = route_q;
endmodule

// File: rtl/wh_inport_ctrl.sv
module wh_inport_ctrl
  import wh_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NPORT     = 5,
  parameter int DEPTH     = 4,
  parameter int CRED_INIT = 3,
  localparam int PW       = $clog2(NPORT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_kind,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [DW-1:0] rc_hdr,
  input  logic [PW-1:0] rc_port,
  output logic          sa_req,
  output logic          sa_hold,
  output logic [PW-1:0] sa_port,
  input  logic          sa_grant,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] out_port,
  input  logic          cred_ret,
  output logic          err_proto
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(CRED_INIT + 1);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [FW-1:0] fifo_rd;
  logic [AW:0]   fifo_cnt;
  logic          fifo_wr, fifo_full, front_vld;
  logic [CW-1:0] cred_cnt;
  logic          cred_avail;
  logic          pop, send, err_drop;
  logic [PW-1:0] route;
  flit_kind_e    front_kind;

  logic          out_valid_q, err_q;
  logic [1:0]    out_kind_q;
  logic [DW-1:0] out_data_q;
  logic [PW-1:0] out_port_q;

  assign fifo_full  = (fifo_cnt == FULL_CNT);
  assign front_vld  = (fifo_cnt != '0);
  assign fifo_wr    = in_valid && !fifo_full;
  assign front_kind = flit_kind_e'(fifo_rd[FW-1:DW]);
  assign cred_avail = (cred_cnt != '0);

  wh_flit_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fifo_wr),
    .wr_data ({in_kind, in_data}),
    .rd_en   (pop),
    .rd_data (fifo_rd),
    .count   (fifo_cnt)
  );

  wh_credit_ctr #(.CRED_INIT(CRED_INIT), .CW(CW)) u_cred (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (send),
    .give  (cred_ret),
    .count (cred_cnt)
  );

  wh_port_fsm #(.PW(PW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .front_vld  (front_vld),
    .front_kind (front_kind),
    .rc_port    (rc_port),
    .sa_grant   (sa_grant),
    .cred_avail (cred_avail),
    .route      (route),
    .pop        (pop),
    .send       (send),
    .err_drop   (err_drop),
    .sa_req     (sa_req),
    .sa_hold    (sa_hold)
  );

  // link traversal stage: control bits reset, data path enabled by send
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      out_valid_q <= send;
      err_q       <= err_drop;
    end
  end

  always_ff @(posedge clk) begin
    if (send) begin
      out_kind_q <= fifo_rd[FW-1:DW];
      out_data_q <= fifo_rd[DW-1:0];
      out_port_q <= route;
    end
  end

  assign in_ready  = !fifo_full;
  assign rc_hdr    = fifo_rd[DW-1:0];
  assign sa_port   = route;
  assign out_valid = out_valid_q;
  assign out_kind  = out_kind_q;
  assign out_data  = out_data_q;
  assign out_port  = out_port_q;
  assign err_proto = err_q;
endmodule

// File: rtl/wh_inport_chk.sv
module wh_inport_chk #(
  parameter int DEPTH     = 4,
  parameter int CRED_INIT = 3,
  parameter int AW        = 2,
  parameter int CW        = 2,
  parameter int PW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sa_req,
  input logic          sa_hold,
  input logic [PW-1:0] sa_port,
  input logic          sa_grant,
  input logic          out_valid,
  input logic [1:0]    out_kind,
  input logic          err_proto,
  input logic [AW:0]   fifo_cnt,
  input logic [CW-1:0] cred_cnt
);
  localparam logic [AW:0]   MAX_FILL = DEPTH[AW:0];
  localparam logic [CW-1:0] MAX_CRED = CW'(CRED_INIT);

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= MAX_FILL);

  a_r4_req_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sa_req && sa_hold));

  a_r4_grant_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_req && sa_grant) |=> sa_hold);

  a_r3_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((sa_req || sa_hold) && $past(sa_req || sa_hold)) |-> $stable(sa_port));

  a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cred_cnt <= MAX_CRED);

  a_r5_send_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cred_cnt) != '0));

  a_r6_out_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sa_hold));

  a_r7_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'b11) |-> !sa_hold);

  a_r8_err_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |-> (!$past(sa_hold) && !$past(sa_req)));
endmodule

bind wh_inport_ctrl wh_inport_chk #(
  .DEPTH(DEPTH), .CRED_INIT(CRED_INIT), .AW(AW), .CW(CW), .PW(PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sa_req    (sa_req),
  .sa_hold   (sa_hold),
  .sa_port   (sa_port),
  .sa_grant  (sa_grant),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .err_proto (err_proto),
  .fifo_cnt  (fifo_cnt),
  .cred_cnt  (cred_cnt)
);

// File: tb/wh_inport_ctrl_test.sv
module wh_inport_ctrl_test;
  localparam int DW = 8;
  localparam int PW = 3;
  localparam logic [1:0] K_RSVD = 2'b00, K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic [DW-1:0] in_data = '0;
  logic in_ready;
  logic [DW-1:0] rc_hdr;
  logic [PW-1:0] rc_port;
  logic sa_req, sa_hold;
  logic [PW-1:0] sa_port;
  logic sa_grant = 1'b0;
  logic out_valid;
  logic [1:0] out_kind;
  logic [DW-1:0] out_data;
  logic [PW-1:0] out_port;
  logic auto_ret = 1'b0, man_ret = 1'b0;
  logic cred_ret;
  logic err_proto;

  bit auto_grant = 1'b1;
  bit auto_cred  = 1'b1;
  bit done = 1'b0;
  int n_chk = 0, n_fail = 0, n_out = 0, n_err = 0;
  logic [PW-1:0] cur_route = '0;
  logic [DW+PW+1:0] exp_q [$];

  always #10 clk = ~clk;

  assign rc_port  = rc_hdr[PW-1:0];
  assign cred_ret = auto_ret | man_ret;

  wh_inport_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_data(in_data), .in_ready(in_ready), .rc_hdr(rc_hdr), .rc_port(rc_port),
    .sa_req(sa_req), .sa_hold(sa_hold), .sa_port(sa_port), .sa_grant(sa_grant),
    .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data),
    .out_port(out_port), .cred_ret(cred_ret), .err_proto(err_proto)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: starts and ends at a falling edge
  task automatic send_flit(input logic [1:0] k, input logic [DW-1:0] d, input bit expect_out);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_kind  = k;
    in_data  = d;
    if (expect_out) begin
      if (k == K_HEAD) cur_route = d[PW-1:0];
      exp_q.push_back({k, d, cur_route});
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // allocator and credit return models
  always @(negedge clk) begin
    sa_grant = auto_grant && sa_req;
    auto_ret = auto_cred && out_valid;
  end

  // monitor / scoreboard (R1 order, R4 route reuse, R6 content)
  always @(negedge clk) begin
    if (rst_n && err_proto) n_err++;
    if (rst_n && out_valid) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected flit", int'(out_data), -1);
      end else begin
        logic [DW+PW+1:0] e;
        e = exp_q.pop_front();
        check(out_kind == e[DW+PW+1:DW+PW], "R2 out kind", int'(out_kind), int'(e[DW+PW+1:DW+PW]));
        check(out_data == e[DW+PW-1:PW], "R1 out data order", int'(out_data), int'(e[DW+PW-1:PW]));
        check(out_port == e[PW-1:0], "R4 out port", int'(out_port), int'(e[PW-1:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int o0, e0;
    wait_cyc(3);
    // reset state
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R6 reset out_valid", int'(out_valid), 0);
    check(sa_req == 1'b0 && sa_hold == 1'b0, "R3 reset req/hold", int'({sa_req, sa_hold}), 0);
    check(err_proto == 1'b0, "R8 reset err", int'(err_proto), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // packet 1: route 2, body payload low bits differ from route (R4)
    send_flit(K_HEAD, 8'h12, 1);
    send_flit(K_BODY, 8'hA3, 1);
    send_flit(K_BODY, 8'h5C, 1);
    send_flit(K_TAIL, 8'h77, 1);
    wait_cyc(12);
    check(n_out == 4, "R4 packet1 flits out", n_out, 4);
    check(sa_hold == 1'b0 && sa_req == 1'b0, "R7 release after tail", int'({sa_req, sa_hold}), 0);

    // stray body and reserved code while idle (R8, R2)
    o0 = n_out; e0 = n_err;
    send_flit(K_BODY, 8'h44, 0);
    wait_cyc(4);
    check(n_err == e0 + 1, "R8 stray body one-cycle err", n_err, e0 + 1);
    check(n_out == o0, "R8 stray body not forwarded", n_out, o0);
    send_flit(K_RSVD, 8'h45, 0);
    wait_cyc(4);
    check(n_err == e0 + 2, "R2 reserved code treated as body", n_err, e0 + 2);
    check(n_out == o0, "R2 reserved code not forwarded", n_out, o0);

    // head-of-line stall: no grant (R9, R3, R1 full)
    auto_grant = 1'b0;
    o0 = n_out;
    send_flit(K_HEAD, 8'h61, 1);
    send_flit(K_BODY, 8'hE4, 1);
    send_flit(K_TAIL, 8'h6B, 1);
    send_flit(K_HEAD, 8'h33, 1);
    wait_cyc(6);
    check(in_ready == 1'b0, "R1 ready low when full", int'(in_ready), 0);
    check(sa_req == 1'b1, "R3 request raised", int'(sa_req), 1);
    check(sa_port == 3'd1, "R3 requested port", int'(sa_port), 1);
    check(n_out == o0, "R9 nothing passes stalled head", n_out, o0);
    auto_grant = 1'b1;
    send_flit(K_BODY, 8'h90, 1);
    send_flit(K_TAIL, 8'h9F, 1);
    wait_cyc(20);
    check(n_out == o0 + 6, "R9 both packets drained", n_out, o0 + 6);

    // credit stall mid-packet (R5, R6, R7)
    auto_cred = 1'b0;
    o0 = n_out;
    send_flit(K_HEAD, 8'h04, 1);
    send_flit(K_BODY, 8'h21, 1);
    send_flit(K_BODY, 8'h22, 1);
    send_flit(K_TAIL, 8'h23, 1);
    wait_cyc(12);
    check(n_out == o0 + 3, "R5 stops at zero credit", n_out, o0 + 3);
    check(sa_hold == 1'b1, "R7 hold kept before tail", int'(sa_hold), 1);
    man_ret = 1'b1;
    @(negedge clk);
    man_ret = 1'b0;
    check(out_valid == 1'b0, "R6 not yet on link", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_kind == K_TAIL, "R6 tail one cycle after send", int'(out_valid), 1);
    check(sa_hold == 1'b0, "R7 hold dropped with tail", int'(sa_hold), 0);
    man_ret = 1'b1;
    wait_cyc(3);
    man_ret = 1'b0;
    auto_cred = 1'b1;
    wait_cyc(2);

    // back-to-back packets on new routes with full credit (R5, R4)
    o0 = n_out;
    send_flit(K_HEAD, 8'h00, 1);
    send_flit(K_TAIL, 8'hFF, 1);
    send_flit(K_HEAD, 8'h03, 1);
    send_flit(K_BODY, 8'h0C, 1);
    send_flit(K_BODY, 8'h0D, 1);
    send_flit(K_BODY, 8'h0E, 1);
    send_flit(K_TAIL, 8'h0F, 1);
    wait_cyc(25);
    check(n_out == o0 + 7, "R5 sustained flow", n_out, o0 + 7);
    check(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule